// File: doc/BRIEF.md
# Six-Channel Digital Volume Attenuator

This block scales six streams of 24-bit two's-complement audio samples by a per-channel attenuation between 0 dB and -127 dB in half-decibel steps. The channels are grouped as three A/B pairs (channel 2p is A, channel 2p+1 is B). A small register bus sets the codes, the links between channels, the way a level change takes effect, and a per-channel mute. Each channel has its own sample strobe; an attenuated sample appears one clock after the strobe.

Two link options decide which stored code drives a channel. A global link makes every channel use channel 0's code. A pair link makes a B channel use its A channel's code. A 2-bit change-timing field chooses how the applied level follows its target. It can jump at once, walk one half-decibel step per sample, or wait for a sign change of the signal with a timeout. The gain is a 12-entry mantissa covering one 6 dB octave, followed by an arithmetic right shift for each further octave. The product is rounded and saturated back to 24 bits.

Top module: `mvol_atten`

## Requirements
- R1: After reset, out_valid and out_data are zero, every code is 0, links and mutes are off and the change timing is immediate, so a sample passes through unchanged.
- R2: For a sample x processed with applied code c, the output one clock after its strobe is round-half-up(x·M[c mod 12] / 2^(15 + c div 12)), saturated to 24 bits, where M[m] = round(32768·10^(-m/40)). out_valid pulses for exactly that clock, and out_data of a channel holds between strobes.
- R3: A write to a channel code register (address 2+i, data byte) stores min(data, 254), so no code beyond -127 dB is ever applied.
- R4: Bit 0 of the control register (address 0) links all channels: each one uses channel 0's stored code, and the other stored codes have no effect on the output.
- R5: Control bit 1+p links pair p: channel 2p+1 uses channel 2p's stored code and its own stored code has no effect.
- R6: With control bits [7:6] equal to 00 or 11, each sample is scaled by the current target code.
- R7: With bits [7:6] = 01, on each strobe the applied code moves one step toward the target before scaling that sample.
- R8: With bits [7:6] = 10, a differing target is applied to the first sample whose sign bit differs from the previous sample's sign bit on that channel (the sign before any sample counts as positive).
- R9: In mode 10, if no sign change happens, the target is applied to the ZC_LIMIT-th sample counted since the code last matched.
- R10: A set bit i of the mute register (address 1) makes channel i output zero samples while still pulsing out_valid and still tracking its applied code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address: 0 control, 1 mutes, 2+i code of channel i |
| cfg_wdata | input | 8 | Register write data |
| in_valid | input | NCH | Per-channel sample strobe |
| in_data | input | NCH*W | Input samples, channel i in bits [i*W +: W] |
| out_valid | output | NCH | Per-channel output strobe, one clock after in_valid |
| out_data | output | NCH*W | Attenuated samples, same packing as in_data |

## Verification
The bench builds the block with its default width and three pairs, so every one of the 255 codes can be swept on all six channels, with full-scale, minimum, ±1 and scattered sample values. This covers every mantissa entry, every shift and the rounding edges. ZC_LIMIT is lowered to 8 so the zero-cross timeout fires within a few samples, next to the sign-change path. Partial strobe masks show that idle channels hold their output.

// File: rtl/mvol_pkg.sv
package mvol_pkg;
    localparam int CODE_W        = 8;
    localparam int MAX_CODE      = 254;
    localparam int STEPS_PER_OCT = 12;
    localparam int MANT_W        = 16;
    localparam int MANT_FRAC     = 15;

    typedef enum logic [1:0] {
        CHG_NOW  = 2'b00,
        CHG_RAMP = 2'b01,
        CHG_ZC   = 2'b10,
        CHG_RSV  = 2'b11
    } chg_mode_e;

    // round(32768 * 10^(-m/40)), one entry per half-decibel inside an octave
    function automatic logic [MANT_W-1:0] mant_lut(input logic [3:0] m);
        logic [MANT_W-1:0] v;
        case (m)
            4'd0:    v = 16'd32768;
            4'd1:    v = 16'd30935;
            4'd2:    v = 16'd29205;
            4'd3:    v = 16'd27571;
            4'd4:    v = 16'd26029;
            4'd5:    v = 16'd24573;
            4'd6:    v = 16'd23198;
            4'd7:    v = 16'd21900;
            4'd8:    v = 16'd20675;
            4'd9:    v = 16'd19519;
            4'd10:   v = 16'd18427;
            4'd11:   v = 16'd17396;
            default: v = 16'd32768;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/mvol_cfg.sv
module mvol_cfg
    import mvol_pkg::*;
#(
    parameter int NPAIR  = 3,
    parameter int ADDR_W = 4,
    localparam int NCH   = 2 * NPAIR
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [7:0]              wdata,
    output logic [NCH*CODE_W-1:0]   tgt_code,
    output logic [NCH-1:0]          mute,
    output chg_mode_e               mode
);
    typedef struct packed {
        logic                        glob;
        logic [NPAIR-1:0]            plink;
        chg_mode_e                   mode;
        logic [NCH-1:0]              mute;
        logic [NCH-1:0][CODE_W-1:0]  code;
    } cfg_s;

    cfg_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (addr == ADDR_W'(0)) begin
                r_d.glob  = wdata[0];
                r_d.plink = wdata[NPAIR:1];
                r_d.mode  = chg_mode_e'(wdata[7:6]);
            end
            if (addr == ADDR_W'(1)) begin
                r_d.mute = wdata[NCH-1:0];
            end
            for (int i = 0; i < NCH; i++) begin
                if (addr == ADDR_W'(i + 2)) begin
                    r_d.code[i] = (wdata > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            if (r_q.glob) begin
                tgt_code[i*CODE_W +: CODE_W] = r_q.code[0];
            end else if (r_q.plink[i/2]) begin
                tgt_code[i*CODE_W +: CODE_W] = r_q.code[(i/2)*2];
            end else begin
                tgt_code[i*CODE_W +: CODE_W] = r_q.code[i];
            end
        end
    end

    assign mute = r_q.mute;
    assign mode = r_q.mode;
endmodule

// File: rtl/mvol_gain.sv
module mvol_gain
    import mvol_pkg::*;
#(
    parameter int W = 24
) (
    input  logic [W-1:0]       sample,
    input  logic [CODE_W-1:0]  code,
    output logic [W-1:0]       result
);
    localparam int PW = W + MANT_W + 2;
    localparam logic signed [PW-1:0] POS_LIM = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [PW-1:0] NEG_LIM = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

    logic [CODE_W-1:0]     oct;
    logic [3:0]            idx;
    logic [MANT_W-1:0]     mant;
    logic [5:0]            shamt;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  rnd;
    logic signed [PW-1:0]  acc;

    always_comb begin
        oct   = code / CODE_W'(STEPS_PER_OCT);
        idx   = 4'(code - oct * CODE_W'(STEPS_PER_OCT));
        mant  = mant_lut(idx);
        shamt = 6'(oct) + 6'(MANT_FRAC);
        prod  = $signed({{(PW-W){sample[W-1]}}, sample})
              * $signed({{(PW-MANT_W){1'b0}}, mant});
        rnd   = '0;
        rnd[shamt - 6'd1] = 1'b1;
        acc   = (prod + rnd) >>> shamt;
        if (acc > POS_LIM) begin
            result = POS_LIM[W-1:0];
        end else if (acc < NEG_LIM) begin
            result = NEG_LIM[W-1:0];
        end else begin
            result = acc[W-1:0];
        end
    end
endmodule

// File: rtl/mvol_lane.sv
module mvol_lane
    import mvol_pkg::*;
#(
    parameter int W        = 24,
    parameter int ZC_LIMIT = 1024,
    localparam int CNT_W   = $clog2(ZC_LIMIT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [W-1:0]       in_sample,
    input  logic [CODE_W-1:0]  tgt_code,
    input  chg_mode_e          mode,
    input  logic               mute,
    output logic               out_valid,
    output logic [W-1:0]       out_sample,
    output logic [CODE_W-1:0]  cur_code
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              prev_neg;
        logic [CNT_W-1:0]  zcnt;
        logic              ovalid;
        logic [W-1:0]      odata;
    } lane_s;

    lane_s s_d, s_q;
    logic [CODE_W-1:0] eff_code;
    logic [CNT_W-1:0]  cnt_nx;
    logic              sign_flip;
    logic [W-1:0]      scaled;

    mvol_gain #(.W(W)) u_gain (
        .sample (in_sample),
        .code   (eff_code),
        .result (scaled)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ovalid = 1'b0;
        eff_code  = s_q.code;
        cnt_nx    = '0;
        sign_flip = in_sample[W-1] != s_q.prev_neg;
        unique case (mode)
            CHG_RAMP: begin
                if (tgt_code > s_q.code) begin
                    eff_code = CODE_W'(s_q.code + 1'b1);
                end else if (tgt_code < s_q.code) begin
                    eff_code = CODE_W'(s_q.code - 1'b1);
                end
            end
            CHG_ZC: begin
                if (tgt_code != s_q.code) begin
                    if (sign_flip || s_q.zcnt == CNT_W'(ZC_LIMIT - 1)) begin
                        eff_code = tgt_code;
                    end else begin
                        cnt_nx = CNT_W'(s_q.zcnt + 1'b1);
                    end
                end
            end
            default: begin
                eff_code = tgt_code;
            end
        endcase
        if (in_valid) begin
            s_d.code     = eff_code;
            s_d.zcnt     = cnt_nx;
            s_d.prev_neg = in_sample[W-1];
            s_d.ovalid   = 1'b1;
            s_d.odata    = mute ? '0 : scaled;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid  = s_q.ovalid;
    assign out_sample = s_q.odata;
    assign cur_code   = s_q.code;
endmodule

// File: rtl/mvol_atten.sv
module mvol_atten
    import mvol_pkg::*;
#(
    parameter int W        = 24,
    parameter int NPAIR    = 3,
    parameter int ZC_LIMIT = 1024,
    parameter int ADDR_W   = 4,
    localparam int NCH     = 2 * NPAIR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [NCH-1:0]    in_valid,
    input  logic [NCH*W-1:0]  in_data,
    output logic [NCH-1:0]    out_valid,
    output logic [NCH*W-1:0]  out_data
);
    logic [NCH*CODE_W-1:0] tgt_code;
    logic [NCH*CODE_W-1:0] lane_code;
    logic [NCH-1:0]        mute_q;
    chg_mode_e             mode_q;

    mvol_cfg #(.NPAIR(NPAIR), .ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .tgt_code (tgt_code),
        .mute     (mute_q),
        .mode     (mode_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        mvol_lane #(.W(W), .ZC_LIMIT(ZC_LIMIT)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid[i]),
            .in_sample  (in_data[i*W +: W]),
            .tgt_code   (tgt_code[i*CODE_W +: CODE_W]),
            .mode       (mode_q),
            .mute       (mute_q[i]),
            .out_valid  (out_valid[i]),
            .out_sample (out_data[i*W +: W]),
            .cur_code   (lane_code[i*CODE_W +: CODE_W])
        );
    end
endmodule

// File: rtl/mvol_atten_chk.sv
module mvol_atten_chk
    import mvol_pkg::*;
#(
    parameter int W   = 24,
    parameter int NCH = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH-1:0]        in_valid,
    input logic [NCH-1:0]        out_valid,
    input logic [NCH*W-1:0]      out_data,
    input logic [NCH-1:0]        mute_q,
    input logic [1:0]            mode_q,
    input logic [NCH*CODE_W-1:0] lane_code
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // R2: one output strobe per input strobe, one clock later
        p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid[i] |=> out_valid[i]);
        // R2: no strobe means no output pulse and a held sample
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid[i] |=> (!out_valid[i] && $stable(out_data[i*W +: W])));
        // R10: a muted channel emits silence
        p_mute_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[i] && mute_q[i]) |=> (out_data[i*W +: W] == '0));
        // R3: the applied code never exceeds the deepest step
        p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            lane_code[i*CODE_W +: CODE_W] <= CODE_W'(MAX_CODE));
        // R7: while ramping, the applied code moves at most one step per clock
        p_ramp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == CHG_RAMP && $past(mode_q) == CHG_RAMP) |->
            (lane_code[i*CODE_W +: CODE_W] == $past(lane_code[i*CODE_W +: CODE_W])
             || lane_code[i*CODE_W +: CODE_W] == CODE_W'($past(lane_code[i*CODE_W +: CODE_W]) + 1'b1)
             || lane_code[i*CODE_W +: CODE_W] == CODE_W'($past(lane_code[i*CODE_W +: CODE_W]) - 1'b1)));
    end
endmodule

bind mvol_atten mvol_atten_chk #(.W(W), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .mute_q    (mute_q),
    .mode_q    (mode_q),
    .lane_code (lane_code)
);

// File: tb/sim_mvol_atten.sv
module sim_mvol_atten;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 24;
    localparam int NPAIR = 3;
    localparam int NCH   = 6;
    localparam int ZCL   = 8;
    localparam int MAXCYC = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [3:0]        cfg_addr = '0;
    logic [7:0]        cfg_wdata = '0;
    logic [NCH-1:0]    in_valid = '0;
    logic [NCH*W-1:0]  in_data = '0;
    logic [NCH-1:0]    out_valid;
    logic [NCH*W-1:0]  out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int         m_code [NCH];
    int         m_app  [NCH];
    int         m_cnt  [NCH];
    bit         m_prevneg [NCH];
    logic [W-1:0] exp_out [NCH];
    bit         m_glob;
    bit [2:0]   m_pl;
    int         m_mode;
    bit [5:0]   m_mute;

    always #(CLK_PERIOD/2) clk = ~clk;

    mvol_atten #(.W(W), .NPAIR(NPAIR), .ZC_LIMIT(ZCL), .ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [W-1:0] mgain(logic [W-1:0] x, int c);
        longint sx, p, r;
        int m, s, mt;
        sx = longint'($signed(x));
        m  = c % 12;
        s  = c / 12;
        mt = $rtoi(32768.0 * (10.0 ** (-m / 40.0)) + 0.5);
        p  = sx * mt;
        r  = (p + (longint'(1) <<< (14 + s))) >>> (15 + s);
        if (r > 8388607)  r = 8388607;
        if (r < -8388608) r = -8388608;
        return r[W-1:0];
    endfunction

    function automatic int mtgt(int i);
        if (m_glob) return m_code[0];
        if (m_pl[i/2]) return m_code[(i/2)*2];
        return m_code[i];
    endfunction

    task automatic model_sample(int i, logic [W-1:0] x);
        int t, e;
        bit flip;
        t = mtgt(i);
        e = m_app[i];
        flip = x[W-1] != m_prevneg[i];
        if (m_mode == 1) begin
            if (t > e) e++;
            else if (t < e) e--;
            m_cnt[i] = 0;
        end else if (m_mode == 2) begin
            if (t == e) m_cnt[i] = 0;
            else if (flip || m_cnt[i] == ZCL - 1) begin e = t; m_cnt[i] = 0; end
            else m_cnt[i]++;
        end else begin
            e = t;
            m_cnt[i] = 0;
        end
        m_app[i] = e;
        m_prevneg[i] = x[W-1];
        exp_out[i] = m_mute[i] ? '0 : mgain(x, e);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 0) begin
            m_glob = d[0]; m_pl = d[3:1]; m_mode = int'(d[7:6]);
        end else if (a == 1) begin
            m_mute = d[5:0];
        end else if (a >= 2 && a < 8) begin
            m_code[a-2] = (d > 254) ? 254 : int'(d);
        end
    endtask

    task automatic smp(input logic [NCH-1:0] v, input logic [W-1:0] xs [NCH], input string tag);
        for (int i = 0; i < NCH; i++) begin
            in_data[i*W +: W] = xs[i];
            if (v[i]) model_sample(i, xs[i]);
        end
        in_valid = v;
        @(negedge clk);
        in_valid = '0;
        for (int i = 0; i < NCH; i++) begin
            checks++;
            if (out_valid[i] !== v[i] || out_data[i*W +: W] !== exp_out[i]) begin
                fails++;
                $display("FAIL %s ch%0d: actual valid=%0b data=%h, expected valid=%0b data=%h",
                         tag, i, out_valid[i], out_data[i*W +: W], v[i], exp_out[i]);
            end
        end
    endtask

    task automatic fill(output logic [W-1:0] xs [NCH], input int seed);
        for (int i = 0; i < NCH; i++) xs[i] = W'(seed * 40503 + i * 977123 + 31);
    endtask

    initial begin
        logic [W-1:0] xs [NCH];
        for (int i = 0; i < NCH; i++) begin
            m_code[i] = 0; m_app[i] = 0; m_cnt[i] = 0; m_prevneg[i] = 0; exp_out[i] = '0;
        end
        m_glob = 0; m_pl = '0; m_mode = 0; m_mute = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (out_valid !== '0 || out_data !== '0) begin
            fails++;
            $display("FAIL R1 reset: actual valid=%h data=%h, expected 0 and 0", out_valid, out_data);
        end
        // R1: default code passes samples unchanged
        fill(xs, 1);
        smp(6'h3f, xs, "R1");
        xs[0] = 24'h7fffff; xs[1] = 24'h800000;
        smp(6'h3f, xs, "R1");

        // R2/R6: sweep every code, immediate timing
        for (int c = 0; c < 255; c++) begin
            for (int i = 0; i < NCH; i++) wr(4'(2 + i), 8'((c + 37 * i) % 255));
            xs[0] = 24'h7fffff;
            xs[1] = 24'h800000;
            xs[2] = 24'hffffff;
            xs[3] = 24'h000001;
            xs[4] = W'(c * 40503 + 77);
            xs[5] = W'(-(c * 1234 + 5));
            smp(6'h3f, xs, "R2");
        end
        // R2: partial strobes, idle channels hold
        fill(xs, 9);
        smp(6'b010101, xs, "R2");
        fill(xs, 10);
        smp(6'b101010, xs, "R2");

        // R3: out-of-range writes clamp to 254
        wr(4'd2, 8'd255);
        wr(4'd3, 8'd250);
        for (int i = 0; i < NCH; i++) xs[i] = 24'h7fffff;
        smp(6'h3f, xs, "R3");

        // R4: global link
        for (int i = 0; i < NCH; i++) wr(4'(2 + i), 8'(5 + 11 * i));
        wr(4'd0, 8'h01);
        fill(xs, 20);
        smp(6'h3f, xs, "R4");
        wr(4'd5, 8'd100);
        fill(xs, 21);
        smp(6'h3f, xs, "R4");

        // R5: pair links on pairs 0 and 2
        wr(4'd0, 8'b0000_1010);
        fill(xs, 30);
        smp(6'h3f, xs, "R5");
        wr(4'd3, 8'd200);
        wr(4'd7, 8'd1);
        fill(xs, 31);
        smp(6'h3f, xs, "R5");

        // R6: reserved timing code behaves as immediate
        wr(4'd0, 8'hc0);
        wr(4'd2, 8'd40);
        fill(xs, 40);
        smp(6'h3f, xs, "R6");

        // R7: soft ramp up and down
        for (int i = 0; i < NCH; i++) wr(4'(2 + i), 8'd0);
        wr(4'd0, 8'h00);
        fill(xs, 50);
        smp(6'h3f, xs, "R7");
        wr(4'd0, 8'h40);
        for (int i = 0; i < NCH; i++) wr(4'(2 + i), 8'(10 + 3 * i));
        for (int k = 0; k < 30; k++) begin
            fill(xs, 60 + k);
            smp(6'h3f, xs, "R7");
        end
        wr(4'd2, 8'd2);
        wr(4'd4, 8'd24);
        for (int k = 0; k < 14; k++) begin
            fill(xs, 100 + k);
            smp(6'h3f, xs, "R7");
        end

        // R8: zero-cross apply on sign change
        for (int i = 0; i < NCH; i++) wr(4'(2 + i), 8'd0);
        wr(4'd0, 8'h00);
        for (int i = 0; i < NCH; i++) xs[i] = W'(1000 + i);
        smp(6'h3f, xs, "R8");
        wr(4'd0, 8'h80);
        for (int i = 0; i < NCH; i++) wr(4'(2 + i), 8'(24 + i));
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < NCH; i++) xs[i] = W'(5000 + 100 * k + i);
            smp(6'h3f, xs, "R8");
        end
        for (int i = 0; i < NCH; i++) xs[i] = W'(-(7000 + i));
        smp(6'h3f, xs, "R8");

        // R9: timeout after ZC_LIMIT samples without crossing
        for (int i = 0; i < NCH; i++) wr(4'(2 + i), 8'(48 + i));
        for (int k = 0; k < ZCL + 2; k++) begin
            for (int i = 0; i < NCH; i++) xs[i] = W'(-(90000 + 50 * k + i));
            smp(6'h3f, xs, "R9");
        end

        // R10: mute some channels, then release
        wr(4'd0, 8'h00);
        wr(4'd1, 8'b101010);
        fill(xs, 200);
        smp(6'h3f, xs, "R10");
        wr(4'd3, 8'd0);
        fill(xs, 201);
        smp(6'h3f, xs, "R10");
        wr(4'd1, 8'h00);
        fill(xs, 202);
        smp(6'h3f, xs, "R10");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (MAXCYC) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual still running, expected finished within %0d cycles", MAXCYC);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule